// File: doc/BRIEF.md
# Interval Timer with Tap-Bit Overflow Interrupt

This block keeps a free-running binary up-counter that advances on every qualified tick of an internal count clock. Software picks one of several counter bits as the interval tap. Each time an increment carries out of that bit, so that the bit falls from 1 to 0, a sticky overflow flag is set. The block drives one level-sensitive interrupt request line to the processor. The line is high while the flag and an interrupt-enable bit are both set.

Software reaches the block through a single write port and a read-back word. The word holds a counter-clear command, the flag, the enable and the interval-select field.

The clear command is a write-one pulse that zeroes the whole counter. The flag clears only when software writes 0 to it, and writing 1 leaves it unchanged. The rules that decide between a flag set, a flag clear and a counter clear in the same cycle are fixed, so that no overflow is lost and a cleared counter never reports a stale interval.

Top module: `interval_timer`

## Requirements
- R1: On a clock with `tick_en` high and no clear command, `count_val` increases by exactly one, wrapping at the counter width. With `tick_en` low and no clear command it holds its value.
- R2: A write with control bit 0 set is a clear command. On the next clock `count_val` becomes 0, even if `tick_en` was high. Bit 0 always reads back as 0.
- R3: Control bits [4:3] select the tap: 0, 1, 2 and 3 choose counter bits 12, 14, 16 and 21 by default. An overflow is an increment that changes the selected bit from 1 to 0.
- R4: An overflow on the selected tap sets the flag (read-back bit 1) on the same clock edge that updates the counter. The enable value has no effect on this.
- R5: A write with bit 1 equal to 0 clears the flag. A write with bit 1 equal to 1 leaves the flag unchanged.
- R6: When an overflow and a write of 0 to the flag fall in the same cycle, the flag ends up set.
- R7: When a clear command and an overflow fall in the same cycle, the flag is not set by that overflow.
- R8: `irq` is high exactly while the flag and the enable (bit 2) are both 1. If the flag is already set, writing the enable to 1 raises `irq` in the first cycle after that write.
- R9: A single write with enable 1 and flag 0 leaves `irq` low, even when the flag was set before the write.
- R10: A synchronous active-high reset zeroes the counter, the flag, the enable and the select field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count qualifier; the counter advances when high |
| wr_en | input | 1 | Control write strobe |
| wr_data | input | 5 | Write word: [0] clear, [1] flag, [2] enable, [4:3] tap select |
| rd_data | output | 5 | Read-back word in the same layout, bit 0 always 0 |
| count_val | output | 22 | Current counter value |
| irq | output | 1 | Level interrupt request |

## Verification
A hardware flag set from a tap overflow can meet two software actions in the same cycle: a write that clears the flag, and a clear command to the counter. The bench steps the counter to one tick short of a carry out of the selected bit. In that exact cycle it issues either a flag-clear write or a counter-clear write while the tick is high. The result is judged by the flag and counter value read back after the edge. A set must win over the write of 0. A counter clear must zero the counter and leave the flag at 0. Random traffic with frequent writes near small taps creates further coincidences, and a reference model updated every cycle from the requirements checks each of them.

// File: rtl/tbtm_pkg.sv
package tbtm_pkg;

   // control word bit positions
   localparam int unsigned CLR_BIT  = 0;
   localparam int unsigned FLAG_BIT = 1;
   localparam int unsigned EN_BIT   = 2;
   localparam int unsigned SEL_LSB  = 3;

   // width of the interval select field for a given tap count
   function automatic int unsigned sel_width(input int unsigned n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

   // width of the whole control word
   function automatic int unsigned ctrl_width(input int unsigned n);
      return SEL_LSB + sel_width(n);
   endfunction

endpackage

// File: rtl/tbtm_counter.sv
module tbtm_counter #(
   parameter int unsigned CNT_W = 22
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick,
   input  logic             clr,
   output logic [CNT_W-1:0] cnt_q
);

   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic [CNT_W-1:0] cnt_d;

   // clear outranks the count tick
   always_comb begin
      cnt_d = cnt_q;
      if (clr)
         cnt_d = '0;
      else if (tick)
         cnt_d = cnt_q + ONE;
   end

   always_ff @(posedge clk) begin
      if (rst)
         cnt_q <= '0;
      else
         cnt_q <= cnt_d;
   end

endmodule

// File: rtl/tbtm_tap_sel.sv
module tbtm_tap_sel #(
   parameter int unsigned CNT_W   = 22,
   parameter int unsigned TAP_CNT = 4,
   parameter int unsigned SEL_W   = 2,
   parameter int unsigned TAP_POS [TAP_CNT] = '{default: 0}
) (
   input  logic [CNT_W-1:0] cnt_q,
   input  logic             tick,
   input  logic [SEL_W-1:0] sel,
   output logic             ovf_hit
);

   localparam int unsigned SEL_SPAN = 1 << SEL_W;

   logic [TAP_CNT-1:0] carry_out;

   // a carry leaves bit p when bits [p:0] are all ones and the counter ticks
   for (genvar k = 0; k < TAP_CNT; k++) begin : g_tap
      if (TAP_POS[k] >= CNT_W) begin : g_bad
         $error("tap position %0d outside a %0d-bit counter", TAP_POS[k], CNT_W);
      end
      assign carry_out[k] = tick & (&cnt_q[TAP_POS[k]:0]);
   end

   if (TAP_CNT == SEL_SPAN) begin : g_full
      // every select code maps to a tap
      assign ovf_hit = carry_out[sel];
   end else begin : g_part
      // unused codes select no tap
      logic hit_v;
      always_comb begin
         hit_v = 1'b0;
         for (int unsigned i = 0; i < TAP_CNT; i++) begin
            if (sel == SEL_W'(i))
               hit_v = carry_out[i];
         end
      end
      assign ovf_hit = hit_v;
   end

endmodule

// File: rtl/tbtm_ctrl.sv
module tbtm_ctrl
   import tbtm_pkg::*;
#(
   parameter int unsigned SEL_W  = 2,
   parameter int unsigned CTRL_W = SEL_LSB + SEL_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [CTRL_W-1:0] wr_data,
   input  logic              ovf_hit,
   output logic              clr_cmd,
   output logic              flag_q,
   output logic              en_q,
   output logic [SEL_W-1:0]  sel_q,
   output logic [CTRL_W-1:0] rd_data,
   output logic              irq
);

   logic             flag_d;
   logic             en_d;
   logic [SEL_W-1:0] sel_d;
   logic             set_ok;

   assign clr_cmd = wr_en & wr_data[CLR_BIT];

   // a counter clear in the same cycle hides the overflow
   assign set_ok = ovf_hit & ~clr_cmd;

   // hardware set outranks the software write of zero
   always_comb begin
      flag_d = flag_q;
      if (set_ok)
         flag_d = 1'b1;
      else if (wr_en && !wr_data[FLAG_BIT])
         flag_d = 1'b0;
   end

   always_comb begin
      en_d  = en_q;
      sel_d = sel_q;
      if (wr_en) begin
         en_d  = wr_data[EN_BIT];
         sel_d = wr_data[SEL_LSB +: SEL_W];
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         flag_q <= 1'b0;
         en_q   <= 1'b0;
         sel_q  <= '0;
      end else begin
         flag_q <= flag_d;
         en_q   <= en_d;
         sel_q  <= sel_d;
      end
   end

   always_comb begin
      rd_data                    = '0;
      rd_data[FLAG_BIT]          = flag_q;
      rd_data[EN_BIT]            = en_q;
      rd_data[SEL_LSB +: SEL_W]  = sel_q;
   end

   assign irq = flag_q & en_q;

endmodule

// File: rtl/interval_timer.sv
module interval_timer
   import tbtm_pkg::*;
#(
   parameter int unsigned CNT_W   = 22,
   parameter int unsigned TAP_CNT = 4,
   parameter int unsigned TAP_POS [TAP_CNT] = '{12, 14, 16, 21}
) (
   input  logic                           clk,
   input  logic                           rst,
   input  logic                           tick_en,
   input  logic                           wr_en,
   input  logic [ctrl_width(TAP_CNT)-1:0] wr_data,
   output logic [ctrl_width(TAP_CNT)-1:0] rd_data,
   output logic [CNT_W-1:0]               count_val,
   output logic                           irq
);

   localparam int unsigned SEL_W  = sel_width(TAP_CNT);
   localparam int unsigned CTRL_W = ctrl_width(TAP_CNT);

   if (CNT_W < 2) begin : g_bad_w
      $error("counter width %0d too small", CNT_W);
   end
   if (TAP_CNT < 2) begin : g_bad_n
      $error("at least two taps needed, got %0d", TAP_CNT);
   end

   logic             clr_cmd;
   logic             ovf_hit;
   logic             flag_q;
   logic             en_q;
   logic [SEL_W-1:0] sel_q;

   tbtm_counter #(
      .CNT_W (CNT_W)
   ) u_cnt (
      .clk   (clk),
      .rst   (rst),
      .tick  (tick_en),
      .clr   (clr_cmd),
      .cnt_q (count_val)
   );

   tbtm_tap_sel #(
      .CNT_W   (CNT_W),
      .TAP_CNT (TAP_CNT),
      .SEL_W   (SEL_W),
      .TAP_POS (TAP_POS)
   ) u_tap (
      .cnt_q   (count_val),
      .tick    (tick_en),
      .sel     (sel_q),
      .ovf_hit (ovf_hit)
   );

   tbtm_ctrl #(
      .SEL_W  (SEL_W),
      .CTRL_W (CTRL_W)
   ) u_ctrl (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .ovf_hit (ovf_hit),
      .clr_cmd (clr_cmd),
      .flag_q  (flag_q),
      .en_q    (en_q),
      .sel_q   (sel_q),
      .rd_data (rd_data),
      .irq     (irq)
   );

endmodule

// File: rtl/interval_timer_chk.sv
module interval_timer_chk
   import tbtm_pkg::*;
#(
   parameter int unsigned CNT_W  = 22,
   parameter int unsigned CTRL_W = 5
) (
   input logic              clk,
   input logic              rst,
   input logic              tick_en,
   input logic              wr_en,
   input logic [CTRL_W-1:0] wr_data,
   input logic [CTRL_W-1:0] rd_data,
   input logic [CNT_W-1:0]  count_val,
   input logic              irq,
   input logic              ovf_hit
);

   logic clr_w;
   assign clr_w = wr_en & wr_data[CLR_BIT];

   // R1
   count_step_chk: assert property (@(posedge clk) disable iff (rst)
      (tick_en && !clr_w) |=> count_val == CNT_W'($past(count_val) + 1'b1));

   // R1
   count_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!tick_en && !clr_w) |=> $stable(count_val));

   // R2
   clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
      clr_w |=> count_val == '0);

   // R2
   clear_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
      rd_data[CLR_BIT] == 1'b0);

   // R4 R6
   flag_set_chk: assert property (@(posedge clk) disable iff (rst)
      (ovf_hit && !clr_w) |=> rd_data[FLAG_BIT]);

   // R7
   clear_hides_ovf_chk: assert property (@(posedge clk) disable iff (rst)
      (ovf_hit && clr_w && !rd_data[FLAG_BIT]) |=> !rd_data[FLAG_BIT]);

   // R5
   write_one_inert_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_data[FLAG_BIT] && !ovf_hit && !rd_data[FLAG_BIT]) |=> !rd_data[FLAG_BIT]);

   // R8
   irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
      irq |-> (rd_data[FLAG_BIT] && rd_data[EN_BIT]));

   // R9
   safe_enable_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && !wr_data[FLAG_BIT] && !ovf_hit) |=> !irq);

endmodule

bind interval_timer interval_timer_chk #(
   .CNT_W  (CNT_W),
   .CTRL_W (CTRL_W)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .tick_en   (tick_en),
   .wr_en     (wr_en),
   .wr_data   (wr_data),
   .rd_data   (rd_data),
   .count_val (count_val),
   .irq       (irq),
   .ovf_hit   (ovf_hit)
);

// File: tb/interval_timer_bench.sv
module interval_timer_bench;

   localparam int unsigned CW = 10;
   localparam int unsigned DW = 5;
   localparam int unsigned TAPS [4] = '{3, 5, 7, 9};

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          tick_en = 1'b0;
   logic          wr_en = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic [DW-1:0] rd_data;
   logic [CW-1:0] count_val;
   logic          irq;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   // reference state
   logic [CW-1:0] m_cnt;
   logic          m_flag, m_en;
   logic [1:0]    m_sel;

   always #2 clk = ~clk;

   interval_timer #(
      .CNT_W   (CW),
      .TAP_CNT (4),
      .TAP_POS (TAPS)
   ) u_interval_timer (
      .clk       (clk),
      .rst       (rst),
      .tick_en   (tick_en),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .rd_data   (rd_data),
      .count_val (count_val),
      .irq       (irq)
   );

   function automatic logic [DW-1:0] word(bit clr, bit flg, bit en, logic [1:0] sel);
      return {sel, en, flg, clr};
   endfunction

   // overflow per R3: increment moves the selected tap from 1 to 0
   function automatic bit ovf_of(logic [CW-1:0] c, logic [1:0] s, bit t);
      logic [CW-1:0] n;
      n = c + 1'b1;
      return t && c[TAPS[s]] && !n[TAPS[s]];
   endfunction

   task automatic check(string tag, string what, int act, int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic compare(string tag);
      check(tag, "count", int'(count_val), int'(m_cnt));
      check(tag, "rd_data", int'(rd_data), int'(word(1'b0, m_flag, m_en, m_sel)));
      check(tag, "irq", int'(irq), int'(m_flag & m_en));
   endtask

   // one clock: drive at negedge, update the model at posedge, sample at next negedge
   task automatic step(bit t, bit w, logic [DW-1:0] d, string tag);
      bit ov, clr;
      tick_en = t;
      wr_en   = w;
      wr_data = d;
      @(posedge clk);
      ov  = ovf_of(m_cnt, m_sel, t);
      clr = w && d[0];
      if (ov && !clr)       m_flag = 1'b1;
      else if (w && !d[1])  m_flag = 1'b0;
      if (clr)              m_cnt = '0;
      else if (t)           m_cnt = m_cnt + 1'b1;
      if (w) begin
         m_en  = d[2];
         m_sel = d[4:3];
      end
      @(negedge clk);
      tick_en = 1'b0;
      wr_en   = 1'b0;
      compare(tag);
   endtask

   task automatic run_to(logic [CW-1:0] target, string tag);
      for (int i = 0; i < (1 << CW) && count_val != target; i++)
         step(1'b1, 1'b0, '0, tag);
   endtask

   initial begin
      void'($urandom(32'h1c0ffee5));
      m_cnt = '0; m_flag = 1'b0; m_en = 1'b0; m_sel = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R10 reset state
      compare("R10");

      // R1 counting and holding
      repeat (5) step(1'b1, 1'b0, '0, "R1");
      check("R1", "count after five ticks", int'(count_val), 5);
      repeat (2) step(1'b0, 1'b0, '0, "R1");
      check("R1", "count held", int'(count_val), 5);

      // R3 R4 tap 0 (bit 3), enable off
      step(1'b0, 1'b1, word(1, 1, 0, 2'd0), "R2");
      check("R2", "count cleared", int'(count_val), 0);
      run_to(15, "R3");
      check("R3", "flag before carry", int'(rd_data[1]), 0);
      step(1'b1, 1'b0, '0, "R4");
      check("R4", "flag set with enable off", int'(rd_data[1]), 1);
      check("R4", "irq gated", int'(irq), 0);

      // R8 enable with stale flag
      step(1'b0, 1'b1, word(0, 1, 1, 2'd0), "R8");
      check("R8", "irq after enable", int'(irq), 1);

      // R5 write one keeps, write zero clears
      step(1'b0, 1'b1, word(0, 1, 1, 2'd0), "R5");
      check("R5", "flag kept", int'(rd_data[1]), 1);
      step(1'b0, 1'b1, word(0, 0, 1, 2'd0), "R5");
      check("R5", "flag cleared", int'(rd_data[1]), 0);

      // R6 set vs write zero
      run_to(31, "R6");
      step(1'b1, 1'b1, word(0, 0, 0, 2'd0), "R6");
      check("R6", "set wins", int'(rd_data[1]), 1);

      // R7 clear with overflow
      step(1'b0, 1'b1, word(1, 0, 0, 2'd0), "R7");
      run_to(15, "R7");
      step(1'b1, 1'b1, word(1, 1, 0, 2'd0), "R7");
      check("R7", "flag suppressed", int'(rd_data[1]), 0);
      check("R7", "count zero", int'(count_val), 0);

      // R9 enable and clear together
      run_to(16, "R9");
      check("R9", "flag pending", int'(rd_data[1]), 1);
      step(1'b0, 1'b1, word(0, 0, 1, 2'd0), "R9");
      check("R9", "irq stays low", int'(irq), 0);

      // R3 tap 2 (bit 7)
      step(1'b0, 1'b1, word(1, 0, 1, 2'd2), "R3");
      run_to(255, "R3");
      check("R3", "no flag at 255", int'(rd_data[1]), 0);
      step(1'b1, 1'b0, '0, "R3");
      check("R3", "flag at 256", int'(rd_data[1]), 1);
      check("R8", "irq with tap 2", int'(irq), 1);

      // random mix
      for (int i = 0; i < 6000; i++) begin
         bit t, w;
         logic [DW-1:0] d;
         t = ($urandom % 8) != 0;
         w = ($urandom % 12) == 0;
         d = DW'($urandom);
         d[0] = ($urandom % 6) == 0;
         d[4] = ($urandom % 3) == 0 ? d[4] : 1'b0;
         step(t, w, d, "R1-random");
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(4 * 150000);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog count %0d expected finish", n_run);
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule